// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a two-channel serial audio stream into parallel left and right sample words. It runs on the incoming bit clock and reads the data line and the word clock on every rising edge of that clock. A three-bit format input chooses the frame format: right-aligned words of 16, 20 or 24 bits, a 24-bit word that starts on the word-clock edge, or the 24-bit I2S layout with its one-slot delay.

Right-aligned formats put the least significant bit in the last slot before the word clock changes. The block therefore keeps the most recent bits in a shift register and takes the word when that edge arrives, so it never needs to know the number of bit clocks per half-frame. The other two formats count slots from the edge. Each completed left/right pair is presented as two 24-bit words. Shorter words are aligned to the top, and a one-cycle valid strobe marks each new pair.

Top module: `aud_serial_rx`

## Requirements
- R1: Serial data and the word clock are sampled on the rising edge of `bclk_i`. Each word is transmitted most significant bit first and is delivered unchanged as a two's-complement value.
- R2: `fmt_i` selects the format: 3'b000 = 16-bit right-aligned, 3'b001 = 20-bit right-aligned, 3'b010 = 24-bit edge-aligned, 3'b011 = 24-bit I2S, 3'b100 = 24-bit right-aligned.
- R3: In the right-aligned formats the word is taken from the last N slots before the word-clock edge. Slots earlier in the half-frame have no effect on the output.
- R4: In the edge-aligned format the MSB occupies the first slot after the word-clock edge. Slots after the 24th have no effect on the output.
- R5: In I2S format the MSB arrives one slot after the word-clock edge, and a low word clock marks the left channel. The LSB may fall in the first slot of the following half-frame.
- R6: In every format other than I2S, a high word clock marks the left channel.
- R7: Decoding is correct at 16 slots per half-frame in format 000, at 20 slots in format 001, at 24 slots in formats 010, 011 and 100, and at any larger slot count, including odd counts.
- R8: 16-bit and 20-bit words are left-aligned in the 24-bit outputs, and their unused low bits are zero.
- R9: `valid_o` pulses for exactly one cycle after each right word has been fully captured, when a left word was captured before it. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R10: While reset is low, `valid_o`, `left_o` and `right_o` are zero. After reset, no strobe is issued until both a left and a right word have been captured. In a right-aligned format this means the third word-clock edge; in the other formats it is the end of the first full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; also the block clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| wclk_i | input | 1 | Word clock (selects the channel) |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 3 | Frame format select |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle new-pair strobe |

## Verification
Some rules can be checked on every cycle. The assertions watch the width of the strobe, confirm that the outputs stay fixed between strobes, confirm that the low bits are zero for short words, and confirm that reset clears everything. Other properties depend on the actual data: the correct bit order, the one-slot I2S delay, which word-clock level means which channel, and the fact that filler slots are ignored. These only show up when specific frames are sent at specific slot counts. So the bench sends known frames at the minimum and at larger slot counts, and it counts strobes from reset to confirm the start-up rule.

// File: rtl/aud_rx_pkg.sv
// Package: shared format codes and word sizes for the audio serial receiver.
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;

    // Frame format codes as driven on fmt_i.
    typedef enum logic [2:0] {
        FMT_TAIL16 = 3'b000,
        FMT_TAIL20 = 3'b001,
        FMT_HEAD24 = 3'b010,
        FMT_I2S24  = 3'b011,
        FMT_TAIL24 = 3'b100
    } fmt_e;

    // True for the formats whose LSB sits just before the word-clock edge.
    function automatic logic is_tail_fmt(input logic [2:0] f);
        return (f == FMT_TAIL16) || (f == FMT_TAIL20) || (f == FMT_TAIL24);
    endfunction

endpackage

// File: rtl/aud_rx_wclk.sv
// Module: aud_rx_wclk
// Finds word-clock edges and tells which channel the current and the
// previous half-frame belong to. In I2S format it works on a copy of the
// word clock delayed by one bit clock, so that I2S decodes like the
// edge-aligned format. Assumes the word clock is steady around rising bclk.
module aud_rx_wclk (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic wclk_i,
    input  logic i2s_i,
    output logic edge_o,
    output logic cur_left_o,
    output logic prev_left_o
);

    logic wclk_d1;
    logic wclk_d2;
    logic eff_cur;
    logic eff_prev;

    // Keep two delayed copies of the word clock.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            wclk_d1 <= 1'b0;
            wclk_d2 <= 1'b0;
        end else begin
            wclk_d1 <= wclk_i;
            wclk_d2 <= wclk_d1;
        end
    end

    // Choose the effective word clock and decode the channel polarity.
    always_comb begin
        eff_cur     = i2s_i ? wclk_d1 : wclk_i;
        eff_prev    = i2s_i ? wclk_d2 : wclk_d1;
        edge_o      = eff_cur ^ eff_prev;
        cur_left_o  = i2s_i ? ~eff_cur  : eff_cur;
        prev_left_o = i2s_i ? ~eff_prev : eff_prev;
    end

endmodule

// File: rtl/aud_rx_capture.sv
// Module: aud_rx_capture
// Shifts every data bit into a register and counts the slots since the
// last effective word-clock edge. In the right-aligned formats it presents
// the last N bits at the edge. In the other formats it presents 24 bits
// once 24 slots have been taken. The capture pulse and the word are
// combinational, and they are valid in the cycle of cap_o.
module aud_rx_capture #(
    parameter int W = aud_rx_pkg::SAMPLE_W
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         sdata_i,
    input  logic [2:0]   fmt_i,
    input  logic         edge_i,
    input  logic         cur_left_i,
    input  logic         prev_left_i,
    output logic         cap_o,
    output logic         cap_left_o,
    output logic [W-1:0] word_o
);
    import aud_rx_pkg::*;

    localparam int CNT_W = $clog2(W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             tail;

    // Shift in the data bit on each rising bit clock.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) shreg <= '0;
        else          shreg <= {shreg[W-2:0], sdata_i};
    end

    // Count the slots since the last edge; saturate so a long half never wraps.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)          cnt <= CNT_MAX;
        else if (edge_i)       cnt <= CNT_W'(1);
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Decide when a word is complete and which channel it belongs to.
    always_comb begin
        tail       = is_tail_fmt(fmt_i);
        idx        = edge_i ? '0 : cnt;
        cap_o      = tail ? edge_i : (idx == LAST_IDX);
        cap_left_o = tail ? prev_left_i : cur_left_i;
    end

    // Form the left-aligned word for the selected format.
    always_comb begin
        case (fmt_i)
            FMT_TAIL16: word_o = {shreg[15:0], {(W-16){1'b0}}};
            FMT_TAIL20: word_o = {shreg[19:0], {(W-20){1'b0}}};
            FMT_TAIL24: word_o = shreg;
            default:    word_o = {shreg[W-2:0], sdata_i};
        endcase
    end

endmodule

// File: rtl/aud_rx_pair.sv
// Module: aud_rx_pair
// Holds the left word until its right partner arrives, then updates both
// outputs and raises the strobe for one cycle. A right word with no left
// word before it (start-up, format change) is dropped.
module aud_rx_pair #(
    parameter int W = aud_rx_pkg::SAMPLE_W
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         cap_i,
    input  logic         cap_left_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);

    logic [W-1:0] left_hold;
    logic         left_done;

    // Pair the left and right words and issue the strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            left_hold <= '0;
            left_done <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap_i && cap_left_i) begin
                left_hold <= word_i;
                left_done <= 1'b1;
            end else if (cap_i && left_done) begin
                left_o    <= left_hold;
                right_o   <= word_i;
                valid_o   <= 1'b1;
                left_done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/aud_serial_rx.sv
// Module: aud_serial_rx (top)
// Receiver for serial stereo audio in five frame formats. The bit clock is
// the block clock. Assumes the word clock and the data change away from
// rising bclk, and that fmt_i stays steady while a stream is received.
module aud_serial_rx #(
    parameter int W = aud_rx_pkg::SAMPLE_W
) (
    input  logic         bclk_i,
    input  logic         rst_n_i,
    input  logic         wclk_i,
    input  logic         sdata_i,
    input  logic [2:0]   fmt_i,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);
    import aud_rx_pkg::*;

    logic         i2s;
    logic         wc_edge;
    logic         cur_left;
    logic         prev_left;
    logic         cap;
    logic         cap_left;
    logic [W-1:0] word;

    // Flag the format that needs the one-slot word-clock delay.
    always_comb i2s = (fmt_i == FMT_I2S24);

    aud_rx_wclk i_wclk (
        .clk_i       (bclk_i),
        .rst_n_i     (rst_n_i),
        .wclk_i      (wclk_i),
        .i2s_i       (i2s),
        .edge_o      (wc_edge),
        .cur_left_o  (cur_left),
        .prev_left_o (prev_left)
    );

    aud_rx_capture #(.W(W)) i_capture (
        .clk_i       (bclk_i),
        .rst_n_i     (rst_n_i),
        .sdata_i     (sdata_i),
        .fmt_i       (fmt_i),
        .edge_i      (wc_edge),
        .cur_left_i  (cur_left),
        .prev_left_i (prev_left),
        .cap_o       (cap),
        .cap_left_o  (cap_left),
        .word_o      (word)
    );

    aud_rx_pair #(.W(W)) i_pair (
        .clk_i      (bclk_i),
        .rst_n_i    (rst_n_i),
        .cap_i      (cap),
        .cap_left_i (cap_left),
        .word_i     (word),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

endmodule

// File: rtl/aud_serial_rx_chk.sv
// Module: aud_serial_rx_chk
// Checker bound to aud_serial_rx. It watches only the top-level ports.
module aud_serial_rx_chk #(
    parameter int W = aud_rx_pkg::SAMPLE_W
) (
    input logic         clk_i,
    input logic         rst_n_i,
    input logic [2:0]   fmt_i,
    input logic [W-1:0] left_o,
    input logic [W-1:0] right_o,
    input logic         valid_o
);

    // R9: the strobe lasts exactly one cycle.
    a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        valid_o |=> !valid_o);

    // R9: the outputs change only together with the strobe.
    a_r9_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

    // R8: a 16-bit right word has zero low bits.
    a_r8_zero_fill16: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (valid_o && $past(fmt_i) == 3'b000) |-> (right_o[W-17:0] == '0));

    // R8: a 20-bit right word has zero low bits.
    a_r8_zero_fill20: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (valid_o && $past(fmt_i) == 3'b001) |-> (right_o[W-21:0] == '0));

    // R10: reset clears the outputs and the strobe.
    a_r10_reset_clear: assert property (@(posedge clk_i)
        !rst_n_i |=> (!valid_o && left_o == '0 && right_o == '0));

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.W(W)) i_chk (
    .clk_i   (bclk_i),
    .rst_n_i (rst_n_i),
    .fmt_i   (fmt_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        sd = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int          checks = 0;
    int          fails = 0;
    int          vcount = 0;
    logic [23:0] cap_l = '0;
    logic [23:0] cap_r = '0;
    logic        pend = 1'b0;

    // Vector fields: mode[58:56], slots per half[55:48], left[47:24], right[23:0].
    localparam int NV = 11;
    localparam logic [58:0] VEC [NV] = '{
        {3'b000, 8'd16, 24'h123400, 24'hFEDC00},
        {3'b000, 8'd32, 24'h7FFFAB, 24'h8000CD},
        {3'b001, 8'd20, 24'hABCDE0, 24'h135790},
        {3'b001, 8'd32, 24'h800017, 24'h7FFFF9},
        {3'b010, 8'd24, 24'hC0FFEE, 24'h012345},
        {3'b010, 8'd32, 24'h800001, 24'h7FFFFE},
        {3'b011, 8'd24, 24'hA5A5A5, 24'h5A5A5B},
        {3'b011, 8'd32, 24'hFFFFFF, 24'h000001},
        {3'b100, 8'd24, 24'h654321, 24'h9ABCDE},
        {3'b100, 8'd27, 24'h000080, 24'hFF0001},
        {3'b010, 8'd27, 24'h3C3C3C, 24'hC3C3C3}
    };

    always #10 clk = ~clk;

    aud_serial_rx i_aud_serial_rx (
        .bclk_i  (clk),
        .rst_n_i (rst_n),
        .wclk_i  (wclk),
        .sdata_i (sd),
        .fmt_i   (mode),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    // Record each strobe and the words it presents, sampled away from the edge.
    always @(negedge clk) begin
        if (valid_o) begin
            vcount = vcount + 1;
            cap_l  = left_o;
            cap_r  = right_o;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int word_len(input logic [2:0] m);
        return (m == 3'b000) ? 16 : (m == 3'b001) ? 20 : 24;
    endfunction

    // The output expected from a 24-bit source word: the top N bits, with low bits zero.
    function automatic logic [23:0] expect_word(input logic [2:0] m, input logic [23:0] w);
        if (m == 3'b000) return {w[23:8], 8'h00};
        if (m == 3'b001) return {w[23:4], 4'h0};
        return w;
    endfunction

    // The serial bit for slot k of a half-frame; filler slots carry ones.
    function automatic logic slot_bit(input logic [2:0] m, input int s, input int k,
                                      input logic [23:0] w, input logic prev);
        int n;
        n = word_len(m);
        if (m == 3'b010) return (k < 24) ? w[23-k] : 1'b1;
        if (m == 3'b011) begin
            if (k == 0) return prev;
            return (k <= 24) ? w[24-k] : 1'b1;
        end
        if (k >= s - n) return w[23-(k-(s-n))];
        return 1'b1;
    endfunction

    task automatic send_half(input logic [2:0] m, input int s, input logic is_left,
                             input logic [23:0] w);
        for (int k = 0; k < s; k++) begin
            @(negedge clk);
            wclk = (m == 3'b011) ? ~is_left : is_left;
            sd   = slot_bit(m, s, k, w, pend);
        end
        pend = w[0];
    endtask

    task automatic send_frame(input logic [2:0] m, input int s,
                              input logic [23:0] l, input logic [23:0] r);
        send_half(m, s, 1'b1, l);
        send_half(m, s, 1'b0, r);
    endtask

    // Hold the word clock still; the first slot carries a pending I2S LSB.
    task automatic tail();
        @(negedge clk);
        sd = pend;
        @(negedge clk);
        sd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Reset, then send four frames and count the strobes.
    task automatic count_run(input logic [2:0] m, input int s, input int exp, input string req);
        int base;
        @(negedge clk);
        rst_n = 1'b0;
        mode  = m;
        wclk  = (m == 3'b011);
        sd    = 1'b0;
        pend  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        base  = vcount;
        repeat (4) send_frame(m, s, 24'h2468AC, 24'hECA864);
        tail();
        check(req, 24'(vcount - base), 24'(exp));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: outputs during reset.
        repeat (3) @(negedge clk);
        check("R10 reset valid", {23'd0, valid_o}, 24'd0);
        check("R10 reset left", left_o, 24'd0);
        check("R10 reset right", right_o, 24'd0);
        rst_n = 1'b1;

        // R1..R8: vector table (formats, polarities, minimum and larger slot counts, filler).
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  m;
            int          s;
            logic [23:0] l;
            logic [23:0] r;
            m = VEC[i][58:56];
            s = int'(VEC[i][55:48]);
            l = VEC[i][47:24];
            r = VEC[i][23:0];
            @(negedge clk);
            mode = m;
            repeat (3) send_frame(m, s, l, r);
            tail();
            check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vec%0d left", i), cap_l, expect_word(m, l));
            check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vec%0d right", i), cap_r, expect_word(m, r));
        end

        // R9 R10: strobe counts from reset (right-aligned, edge-aligned, I2S).
        count_run(3'b000, 16, 3, "R9 R10 strobes right-aligned");
        count_run(3'b010, 24, 4, "R9 R10 strobes edge-aligned");
        count_run(3'b011, 24, 4, "R9 R10 strobes I2S R5");

        // R10: reset in the middle of a stream clears the outputs.
        @(negedge clk);
        mode = 3'b010;
        send_half(3'b010, 24, 1'b1, 24'h111111);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 mid reset left", left_o, 24'd0);
        check("R10 mid reset right", right_o, 24'd0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule